// File: doc/BRIEF.md
# Serial Port Interrupt Identifier

This block sits beside a serial port's receive and transmit paths. It turns the port's pending conditions and status flags into one interrupt identification code and one interrupt request line. It holds the 4-bit interrupt enable register, written through a host strobe. It also keeps its own "transmit holding empty" pending flag. Host writes of a transmit byte, host reads of the identification register and changes to the transmit enable bit set or clear that flag.

Each cycle, a fixed five-level prioritizer picks the highest-ranked enabled source. The chosen code and the request line are registered, so they follow any input change one clock later. The upper bits of the identification byte report whether the FIFOs are enabled.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset the identification byte reads 0x01 (bit 0 set = nothing pending), the request line is low and all four enable bits are zero.
- R2: A line-status source is pending when enable bit 2 is set and any of the four error inputs (overrun, parity, framing, break) is high. It ranks above every other source and gives code 0x6 in the low nibble.
- R3: A character timeout gives code 0xC and ranks second. It is gated by enable bit 0 (the received-data enable), and no separate enable exists for it.
- R4: Received data gives code 0x4 and ranks third, gated by enable bit 0. With FIFOs enabled it also needs the receive count to be at least the trigger level. With FIFOs disabled, data-ready alone is enough.
- R5: Transmit-holding-empty gives code 0x2 and ranks fourth. It needs enable bit 1 and the internal pending flag.
- R6: Modem status gives code 0x0 and ranks last. It needs enable bit 3 and any of the four modem delta inputs.
- R7: Bits 7:6 of the identification byte read 11 while the FIFOs are enabled and 00 otherwise. Bits 5:4 always read 0.
- R8: A read of the identification byte that returns low nibble 0x2 clears the transmit pending flag. A read that returns any other code leaves the flag unchanged.
- R9: A write that turns enable bit 1 from 0 to 1 sets the pending flag if the holding register is empty, and clears it otherwise. A write that turns bit 1 off clears the flag.
- R10: A transmit byte write clears the pending flag.
- R11: A rising edge of the holding-empty input sets the pending flag.
- R12: The request line is high exactly when the registered code is not "nothing pending", and it updates in the same cycle as the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 4 | Enable data: bit0 rx data/timeout, bit1 tx empty, bit2 line status, bit3 modem |
| tx_wr | input | 1 | Transmit byte write strobe |
| id_rd | input | 1 | Identification register read strobe |
| line_err | input | 4 | Overrun, parity, framing, break status |
| rx_ready | input | 1 | Receive data ready |
| fifo_on | input | 1 | FIFOs enabled |
| rx_level | input | CNT_W | Receive FIFO fill count |
| rx_trigger | input | CNT_W | Receive FIFO trigger level |
| rx_timeout | input | 1 | Character timeout pending |
| tx_empty | input | 1 | Transmit holding register empty |
| modem_delta | input | 4 | Modem status change bits |
| irq_id | output | 8 | Registered identification byte |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong pending flag shows up as a stray or missing code 0x2 two clocks after the strobe that should have moved it: one clock for the flag and one for the identification register. The bench hides the flag behind higher sources, then clears those sources to reveal it. This shows that reads returning other codes leave the flag alone. A misordered priority or a wrong gate shows up one clock after the inputs change, as a code that belongs to another source.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    parameter int unsigned RX_DEPTH = 16;
    localparam int unsigned CNT_W   = $clog2(RX_DEPTH + 1);

    // enable bit positions
    localparam int unsigned EN_RXD = 0;
    localparam int unsigned EN_TXE = 1;
    localparam int unsigned EN_LSE = 2;
    localparam int unsigned EN_MDM = 3;

    localparam logic [1:0] FIFO_TAG = 2'b11;

    typedef enum logic [3:0] {
        IID_MDM  = 4'h0,
        IID_NONE = 4'h1,
        IID_TXE  = 4'h2,
        IID_RXD  = 4'h4,
        IID_LINE = 4'h6,
        IID_TMO  = 4'hC
    } iid_code_e;

    // ordered highest priority first
    typedef struct packed {
        logic line;
        logic tmo;
        logic rxd;
        logic txe;
        logic mdm;
    } irq_req_t;

    function automatic iid_code_e pick_iid(irq_req_t r);
        iid_code_e c;
        if (r.line)      c = IID_LINE;
        else if (r.tmo)  c = IID_TMO;
        else if (r.rxd)  c = IID_RXD;
        else if (r.txe)  c = IID_TXE;
        else if (r.mdm)  c = IID_MDM;
        else             c = IID_NONE;
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_txe_track.sv
module uart_irq_txe_track
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_wr,
    input  logic [3:0] en_wdata,
    input  logic       tx_wr,
    input  logic       id_rd,
    input  logic       id_shows_txe,
    input  logic       tx_empty,
    output logic [3:0] en_q,
    output logic       txe_pend
);

    logic empty_d;
    logic pend_nxt;
    logic txe_toggle;

    assign txe_toggle = en_wr && (en_wdata[EN_TXE] != en_q[EN_TXE]);

    always_comb begin
        pend_nxt = txe_pend;
        if (tx_empty && !empty_d)   pend_nxt = 1'b1;
        if (id_rd && id_shows_txe)  pend_nxt = 1'b0;
        if (tx_wr)                  pend_nxt = 1'b0;
        if (txe_toggle)             pend_nxt = en_wdata[EN_TXE] && tx_empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            txe_pend <= 1'b0;
            empty_d  <= 1'b1;
        end else begin
            if (en_wr) en_q <= en_wdata;
            txe_pend <= pend_nxt;
            empty_d  <= tx_empty;
        end
    end

    // R10
    tx_wr_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && !txe_toggle) |=> !txe_pend);

    // R8
    id_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (id_rd && id_shows_txe && !txe_toggle) |=> !txe_pend);

    // R9
    enable_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (en_wr && en_wdata[EN_TXE] && !en_q[EN_TXE] && tx_empty) |=> txe_pend);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic [3:0] en,
    input  logic [3:0] line_err,
    input  logic       rx_ready,
    input  logic       fifo_on,
    input  logic [W-1:0] rx_level,
    input  logic [W-1:0] rx_trigger,
    input  logic       rx_timeout,
    input  logic       txe_pend,
    input  logic [3:0] modem_delta,
    output iid_code_e  code
);

    irq_req_t req;
    logic     rx_enough;

    assign rx_enough = !fifo_on || (rx_level >= rx_trigger);

    always_comb begin
        req.line = en[EN_LSE] && (|line_err);
        req.tmo  = en[EN_RXD] && rx_timeout;
        req.rxd  = en[EN_RXD] && rx_ready && rx_enough;
        req.txe  = en[EN_TXE] && txe_pend;
        req.mdm  = en[EN_MDM] && (|modem_delta);
        code     = pick_iid(req);
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_wr,
    input  logic [3:0]   en_wdata,
    input  logic         tx_wr,
    input  logic         id_rd,
    input  logic [3:0]   line_err,
    input  logic         rx_ready,
    input  logic         fifo_on,
    input  logic [W-1:0] rx_level,
    input  logic [W-1:0] rx_trigger,
    input  logic         rx_timeout,
    input  logic         tx_empty,
    input  logic [3:0]   modem_delta,
    output logic [7:0]   irq_id,
    output logic         irq
);

    logic [3:0] en_q;
    logic       txe_pend;
    logic       id_shows_txe;
    iid_code_e  code;

    assign id_shows_txe = (irq_id[3:0] == IID_TXE);

    uart_irq_txe_track u_track (
        .clk          (clk),
        .rst          (rst),
        .en_wr        (en_wr),
        .en_wdata     (en_wdata),
        .tx_wr        (tx_wr),
        .id_rd        (id_rd),
        .id_shows_txe (id_shows_txe),
        .tx_empty     (tx_empty),
        .en_q         (en_q),
        .txe_pend     (txe_pend)
    );

    uart_irq_prio #(.W(W)) u_prio (
        .en          (en_q),
        .line_err    (line_err),
        .rx_ready    (rx_ready),
        .fifo_on     (fifo_on),
        .rx_level    (rx_level),
        .rx_trigger  (rx_trigger),
        .rx_timeout  (rx_timeout),
        .txe_pend    (txe_pend),
        .modem_delta (modem_delta),
        .code        (code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_id <= {4'h0, IID_NONE};
            irq    <= 1'b0;
        end else begin
            irq_id <= {(fifo_on ? FIFO_TAG : 2'b00), 2'b00, code};
            irq    <= (code != IID_NONE);
        end
    end

    // R2
    line_first_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q[EN_LSE] && (|line_err)) |=> (irq_id[3:0] == IID_LINE));

    // R7
    fifo_tag_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_on |=> (irq_id[7:6] == FIFO_TAG));

    // R12
    irq_match_chk: assert property (@(posedge clk) disable iff (rst)
        irq == !irq_id[0]);

endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
    import uart_irq_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_wr = 0, tx_wr = 0, id_rd = 0;
    logic [3:0]   en_wdata = 0, line_err = 0, modem_delta = 0;
    logic         rx_ready = 0, fifo_on = 0, rx_timeout = 0, tx_empty = 1;
    logic [CNT_W-1:0] rx_level = 0, rx_trigger = 0;
    logic [7:0]   irq_id;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] id;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    uart_irq_ident u0 (
        .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
        .tx_wr(tx_wr), .id_rd(id_rd), .line_err(line_err),
        .rx_ready(rx_ready), .fifo_on(fifo_on), .rx_level(rx_level),
        .rx_trigger(rx_trigger), .rx_timeout(rx_timeout),
        .tx_empty(tx_empty), .modem_delta(modem_delta),
        .irq_id(irq_id), .irq(irq)
    );

    // monitor: mid high phase, inputs stable
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (irq_id !== e.id || irq !== !e.id[0]) begin
                    errors++;
                    $display("FAIL %s: id=%02h irq=%0b expected id=%02h irq=%0b",
                             e.tag, irq_id, irq, e.id, !e.id[0]);
                end
            end
        end
    end

    task automatic expect_id(input logic [7:0] id, input string tag);
        exp_t e;
        @(negedge clk);
        @(negedge clk);
        e.id = id;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic wr_en(input logic [3:0] v);
        en_wr = 1; en_wdata = v;
        @(negedge clk);
        en_wr = 0;
    endtask

    task automatic wr_tx();
        tx_wr = 1;
        @(negedge clk);
        tx_wr = 0;
    endtask

    task automatic rd_id();
        id_rd = 1;
        @(negedge clk);
        id_rd = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: id=%02h expected completion", irq_id);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 0;
        expect_id(8'h01, "R1 reset state");

        wr_en(4'b0010);
        expect_id(8'h02, "R9 R5 enable arms flag while empty");
        rd_id();
        expect_id(8'h01, "R8 read of tx code clears flag");

        tx_empty = 0;
        expect_id(8'h01, "R11 holding full, no flag");
        tx_empty = 1;
        expect_id(8'h02, "R11 rising empty sets flag");
        wr_tx();
        expect_id(8'h01, "R10 tx write clears flag");

        wr_en(4'b0000);
        wr_en(4'b0010);
        expect_id(8'h02, "R9 re-enable rearms");
        wr_en(4'b0000);
        expect_id(8'h01, "R9 disable clears");
        tx_empty = 0;
        wr_en(4'b0010);
        expect_id(8'h01, "R9 enable while full does not arm");

        wr_en(4'b1000);
        modem_delta = 4'b0100;
        expect_id(8'h00, "R6 modem status");

        wr_en(4'b1011);
        rx_ready = 1;
        expect_id(8'h04, "R4 data ready without fifo beats modem");

        fifo_on = 1; rx_level = 3; rx_trigger = 4;
        expect_id(8'hC0, "R4 R7 below trigger falls to modem");
        rx_level = 4;
        expect_id(8'hC4, "R4 count at trigger");

        rx_timeout = 1;
        expect_id(8'hCC, "R3 timeout beats rx data");
        wr_en(4'b1010);
        expect_id(8'hC0, "R3 timeout masked by data enable");

        line_err = 4'b0001;
        expect_id(8'hC0, "R2 line status needs enable");
        wr_en(4'b1111);
        expect_id(8'hC6, "R2 line status highest");

        tx_empty = 1;
        expect_id(8'hC6, "R11 flag hidden below line status");
        rd_id();
        line_err = 0; rx_timeout = 0; rx_ready = 0; modem_delta = 0;
        expect_id(8'hC2, "R8 read of other code keeps flag");

        rd_id();
        expect_id(8'hC1, "R12 R7 nothing pending with fifo");
        fifo_on = 0;
        expect_id(8'h01, "R12 R7 nothing pending without fifo");

        @(negedge clk); @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule